// File: doc/BRIEF.md
# MSI Snooping Cache Coherence Controller

This block is the coherence controller for one private write-back cache that sits on a shared, atomic snooping bus. It holds a small direct-mapped array in which every line carries a two-bit coherence state, a tag and one data word. Processor loads and stores are served locally when the line's state allows it. Otherwise the controller asks for the bus through a request/grant handshake and then issues a read, a read-for-ownership or a write-back.

While it does this, the controller watches transactions that other caches put on the bus. If another cache reads a line that this cache holds dirty, the controller drives the line's word onto the bus and keeps a clean shared copy. If another cache asks for ownership, the local copy is dropped, and a dirty copy is supplied first. Each bus transaction completes in the cycle it is granted. The processor is held off until its own transaction has finished.

Top module: `msi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid: `cpu_ready`, `bus_req` and `flush_valid` are low, a snooped request produces no flush, and the first processor access to any address misses.
- R2: A processor read that misses issues exactly one bus transaction with `bus_cmd` = 1 (read) for the request address. The word on `bus_rdata` is returned, and the line becomes Shared, so a repeated read is a hit.
- R3: A processor read that hits a Shared or Modified line raises `cpu_ready` in the same cycle as the request, returns the stored word and starts no bus transaction.
- R4: A processor write to a line that is not Modified (a miss, or a hit in Shared) issues one transaction with `bus_cmd` = 2 (read-for-ownership), stores the write word, and leaves the line Modified.
- R5: A processor write that hits a Modified line raises `cpu_ready` in the request cycle, updates the word and starts no bus transaction.
- R6: A foreign snooped read (`snp_cmd` = 1) that hits a Modified line raises `flush_valid` with the line's word in the same cycle, and the line becomes Shared. A later write to it therefore needs `bus_cmd` = 2.
- R7: A foreign snooped read that hits a Shared line, or that misses, produces no flush and leaves the line unchanged.
- R8: A foreign snooped read-for-ownership (`snp_cmd` = 2) that hits a valid line invalidates it. If the line was Modified, its word is flushed in the same cycle.
- R9: A miss whose victim line is Modified first issues `bus_cmd` = 3 (write-back) carrying the victim's address and word, and then issues the read or read-for-ownership for the new address. Evicting a Shared victim issues no write-back.
- R10: If a snoop downgrades or invalidates the Modified victim while the write-back is still waiting for grant, the write-back is dropped and only the fetch is issued.
- R11: A snooped transaction marked as this cache's own (`snp_own` = 1) has no effect on any line and never causes a flush.
- R12: A foreign snoop in the same cycle as a new processor request takes precedence: `cpu_ready` stays low in that cycle, and the request is served afterwards.
- R13: `bus_req` stays high until granted, unless a snoop cancels the pending write-back. `bus_cmd` is non-zero only in a cycle with both `bus_req` and `bus_gnt` high. Only one transaction is in flight at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address (tag above index) |
| cpu_wdata | input | DATA_W | Write word |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_rdata | output | DATA_W | Read word, valid with `cpu_ready` |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant; the transaction completes in the granted cycle |
| bus_cmd | output | 2 | 0 none, 1 read, 2 read-for-ownership, 3 write-back |
| bus_addr | output | ADDR_W | Transaction address |
| bus_wdata | output | DATA_W | Write-back word |
| bus_rdata | input | DATA_W | Fill word, sampled at the granted edge |
| snp_valid | input | 1 | A transaction is visible on the bus |
| snp_own | input | 1 | That transaction was issued by this cache |
| snp_cmd | input | 2 | Snooped command, same encoding as `bus_cmd` |
| snp_addr | input | ADDR_W | Snooped address |
| flush_valid | output | 1 | This cache supplies the snooped line's word |
| flush_data | output | DATA_W | Flushed word |

## Verification
The bench goes after the dirty-victim miss. A design that fetched before writing back, or that wrote back a Shared victim, shows the wrong transaction count or order. It also checks a victim that is stolen by a snoop while the controller waits for grant: a design that does not recheck the state writes stale data back to memory. Self-snoops and snoop-versus-request collisions are driven directly. A controller that reacts to its own transaction loses ownership, which shows up as extra bus traffic on the next write. A controller that lets a request through a snoop raises `cpu_ready` too early. Random traffic over conflicting addresses checks each read word against a memory model that takes in flushes and write-backs, so a missed flush appears as a stale read.

// File: rtl/msi_pkg.sv
// Shared types for the MSI snooping coherence controller.
// Assumes a two-bit bus command field shared with the snoop side.
package msi_pkg;
    typedef enum logic [1:0] {LS_I = 2'd0, LS_S = 2'd1, LS_M = 2'd2} line_st_t;
    typedef enum logic [1:0] {BC_NONE = 2'd0, BC_RD = 2'd1, BC_RDX = 2'd2, BC_WB = 2'd3} bus_cmd_t;
    typedef enum logic [1:0] {FS_IDLE, FS_WB, FS_FETCH, FS_DONE} fsm_st_t;
endpackage

// File: rtl/msi_line_store.sv
// Per-line state, tag and data registers with two read ports (processor, snoop)
// and two write ports: a state-only port for snoop actions (higher priority)
// and a full-line port for the request engine. Assumes one writer per line per cycle.
module msi_line_store
    import msi_pkg::*;
#(
    parameter int LINES  = 4,
    parameter int IDX_W  = 2,
    parameter int TAG_W  = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  a_idx,
    output line_st_t          a_st,
    output logic [TAG_W-1:0]  a_tag,
    output logic [DATA_W-1:0] a_dat,
    input  logic [IDX_W-1:0]  b_idx,
    output line_st_t          b_st,
    output logic [TAG_W-1:0]  b_tag,
    output logic [DATA_W-1:0] b_dat,
    input  logic              sw_en,
    input  logic [IDX_W-1:0]  sw_idx,
    input  line_st_t          sw_st,
    input  logic              fw_en,
    input  logic [IDX_W-1:0]  fw_idx,
    input  line_st_t          fw_st,
    input  logic [TAG_W-1:0]  fw_tag,
    input  logic [DATA_W-1:0] fw_dat
);
    line_st_t          st_q  [LINES];
    logic [TAG_W-1:0]  tag_q [LINES];
    logic [DATA_W-1:0] dat_q [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        line_st_t          st_r;
        logic [TAG_W-1:0]  tag_r;
        logic [DATA_W-1:0] dat_r;
        // Line register update: snoop state change wins over a full-line write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_r  <= LS_I;
                tag_r <= '0;
                dat_r <= '0;
            end else if (sw_en && sw_idx == IDX_W'(g)) begin
                st_r <= sw_st;
            end else if (fw_en && fw_idx == IDX_W'(g)) begin
                st_r  <= fw_st;
                tag_r <= fw_tag;
                dat_r <= fw_dat;
            end
        end
        assign st_q[g]  = st_r;
        assign tag_q[g] = tag_r;
        assign dat_q[g] = dat_r;
    end

    // Combinational read ports.
    always_comb begin
        a_st  = st_q[a_idx];
        a_tag = tag_q[a_idx];
        a_dat = dat_q[a_idx];
        b_st  = st_q[b_idx];
        b_tag = tag_q[b_idx];
        b_dat = dat_q[b_idx];
    end
endmodule

// File: rtl/msi_snoop_unit.sv
// Snoop responder: decides flush and state change for a transaction seen on
// the bus. Assumes the addressed line has already been read from the store.
// Transactions marked as this cache's own are ignored.
module msi_snoop_unit
    import msi_pkg::*;
#(
    parameter int TAG_W  = 6,
    parameter int DATA_W = 16
) (
    input  logic              snp_valid,
    input  logic              snp_own,
    input  logic [1:0]        snp_cmd,
    input  logic [TAG_W-1:0]  snp_tag,
    input  line_st_t          l_st,
    input  logic [TAG_W-1:0]  l_tag,
    input  logic [DATA_W-1:0] l_dat,
    output logic              foreign,
    output logic              sw_en,
    output line_st_t          sw_st,
    output logic              flush_valid,
    output logic [DATA_W-1:0] flush_data
);
    logic hit;

    // Snoop decision: flush a dirty line, then downgrade or invalidate.
    always_comb begin
        foreign     = snp_valid && !snp_own;
        hit         = foreign && (l_st != LS_I) && (l_tag == snp_tag);
        sw_en       = 1'b0;
        sw_st       = l_st;
        flush_valid = 1'b0;
        flush_data  = l_dat;
        if (hit && snp_cmd == BC_RD && l_st == LS_M) begin
            flush_valid = 1'b1;
            sw_en       = 1'b1;
            sw_st       = LS_S;
        end else if (hit && snp_cmd == BC_RDX) begin
            flush_valid = (l_st == LS_M);
            sw_en       = 1'b1;
            sw_st       = LS_I;
        end
    end
endmodule

// File: rtl/msi_req_fsm.sv
// Processor-side request engine. Serves hits locally. On a miss it writes back
// a dirty victim and then fetches with read or read-for-ownership. Assumes the
// processor holds its request stable until ready, and that each granted bus
// transaction completes at the granted edge.
module msi_req_fsm
    import msi_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 2,
    parameter int DATA_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cpu_req,
    input  logic                    cpu_we,
    input  logic [ADDR_W-1:0]       cpu_addr,
    input  logic [DATA_W-1:0]       cpu_wdata,
    output logic                    cpu_ready,
    output logic [DATA_W-1:0]       cpu_rdata,
    input  logic                    snoop_busy,
    input  line_st_t                a_st,
    input  logic [ADDR_W-IDX_W-1:0] a_tag,
    input  logic [DATA_W-1:0]       a_dat,
    output logic                    bus_req,
    input  logic                    bus_gnt,
    output logic [1:0]              bus_cmd,
    output logic [ADDR_W-1:0]       bus_addr,
    output logic [DATA_W-1:0]       bus_wdata,
    input  logic [DATA_W-1:0]       bus_rdata,
    output logic                    fw_en,
    output line_st_t                fw_st,
    output logic [ADDR_W-IDX_W-1:0] fw_tag,
    output logic [DATA_W-1:0]       fw_dat
);
    localparam int TAG_W = ADDR_W - IDX_W;

    fsm_st_t           cur, nxt;
    logic [TAG_W-1:0]  cpu_tag;
    logic [IDX_W-1:0]  cpu_idx;
    logic              tag_eq, hit;

    assign cpu_tag = cpu_addr[ADDR_W-1:IDX_W];
    assign cpu_idx = cpu_addr[IDX_W-1:0];
    assign tag_eq  = (a_tag == cpu_tag);
    assign hit     = (a_st != LS_I) && tag_eq;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) cur <= FS_IDLE;
        else        cur <= nxt;
    end

    // Next state, bus drive and line writes for the current step.
    always_comb begin
        nxt       = cur;
        cpu_ready = 1'b0;
        cpu_rdata = a_dat;
        bus_req   = 1'b0;
        bus_cmd   = BC_NONE;
        bus_addr  = cpu_addr;
        bus_wdata = a_dat;
        fw_en     = 1'b0;
        fw_st     = LS_I;
        fw_tag    = cpu_tag;
        fw_dat    = cpu_wdata;
        case (cur)
            FS_IDLE: begin
                if (cpu_req && !snoop_busy) begin
                    if (hit && !cpu_we) begin
                        cpu_ready = 1'b1;
                    end else if (hit && a_st == LS_M) begin
                        cpu_ready = 1'b1;
                        fw_en     = 1'b1;
                        fw_st     = LS_M;
                    end else if (a_st == LS_M && !tag_eq) begin
                        nxt = FS_WB;
                    end else begin
                        nxt = FS_FETCH;
                    end
                end
            end
            FS_WB: begin
                if (a_st != LS_M) begin
                    nxt = FS_FETCH;
                end else begin
                    bus_req = 1'b1;
                    if (bus_gnt) begin
                        bus_cmd  = BC_WB;
                        bus_addr = {a_tag, cpu_idx};
                        fw_en    = 1'b1;
                        fw_st    = LS_I;
                        fw_tag   = a_tag;
                        fw_dat   = a_dat;
                        nxt      = FS_FETCH;
                    end
                end
            end
            FS_FETCH: begin
                bus_req = 1'b1;
                if (bus_gnt) begin
                    bus_cmd = cpu_we ? BC_RDX : BC_RD;
                    fw_en   = 1'b1;
                    fw_st   = cpu_we ? LS_M : LS_S;
                    fw_dat  = cpu_we ? cpu_wdata : bus_rdata;
                    nxt     = FS_DONE;
                end
            end
            default: begin
                cpu_ready = 1'b1;
                nxt       = FS_IDLE;
            end
        endcase
    end
endmodule

// File: rtl/msi_snoop_ctrl.sv
// Top of the MSI coherence controller: line store, snoop responder and request
// engine. Assumes an atomic bus on which a foreign snoop never coincides with a
// grant to this cache.
module msi_snoop_ctrl
    import msi_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LINES  = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic [1:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              snp_valid,
    input  logic              snp_own,
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              flush_valid,
    output logic [DATA_W-1:0] flush_data
);
    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - IDX_W;

    line_st_t          a_st, b_st, sw_st, fw_st;
    logic [TAG_W-1:0]  a_tag, b_tag, fw_tag;
    logic [DATA_W-1:0] a_dat, b_dat, fw_dat;
    logic              sw_en, fw_en, foreign;

    msi_line_store #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .a_idx(cpu_addr[IDX_W-1:0]), .a_st(a_st), .a_tag(a_tag), .a_dat(a_dat),
        .b_idx(snp_addr[IDX_W-1:0]), .b_st(b_st), .b_tag(b_tag), .b_dat(b_dat),
        .sw_en(sw_en), .sw_idx(snp_addr[IDX_W-1:0]), .sw_st(sw_st),
        .fw_en(fw_en), .fw_idx(cpu_addr[IDX_W-1:0]), .fw_st(fw_st),
        .fw_tag(fw_tag), .fw_dat(fw_dat)
    );

    msi_snoop_unit #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_snoop (
        .snp_valid(snp_valid), .snp_own(snp_own), .snp_cmd(snp_cmd),
        .snp_tag(snp_addr[ADDR_W-1:IDX_W]),
        .l_st(b_st), .l_tag(b_tag), .l_dat(b_dat),
        .foreign(foreign), .sw_en(sw_en), .sw_st(sw_st),
        .flush_valid(flush_valid), .flush_data(flush_data)
    );

    msi_req_fsm #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata), .snoop_busy(foreign),
        .a_st(a_st), .a_tag(a_tag), .a_dat(a_dat),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .fw_en(fw_en), .fw_st(fw_st), .fw_tag(fw_tag), .fw_dat(fw_dat)
    );
endmodule

// File: rtl/msi_snoop_ctrl_chk.sv
// Port-level protocol checker for msi_snoop_ctrl, attached by bind.
module msi_snoop_ctrl_chk #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req,
    input logic              cpu_ready,
    input logic              bus_req,
    input logic              bus_gnt,
    input logic [1:0]        bus_cmd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              snp_valid,
    input logic              snp_own,
    input logic [1:0]        snp_cmd,
    input logic              flush_valid
);
    p_cmd_gated_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd != 2'd0) |-> (bus_req && bus_gnt));
    p_req_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt && !(snp_valid && !snp_own)) |=> bus_req);
    p_flush_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |-> (snp_valid && !snp_own && (snp_cmd == 2'd1 || snp_cmd == 2'd2)));
    p_own_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && snp_own) |-> !flush_valid);
    p_wb_then_fetch_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd == 2'd3) |=> bus_req);
    p_ready_needs_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> cpu_req);
endmodule

bind msi_snoop_ctrl msi_snoop_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_ready(cpu_ready),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .snp_valid(snp_valid), .snp_own(snp_own),
    .snp_cmd(snp_cmd), .flush_valid(flush_valid)
);

// File: tb/msi_snoop_ctrl_test.sv
// Bench for msi_snoop_ctrl: directed corner cases plus seeded random traffic,
// checked against a bench-side MSI line model and a memory model.
module msi_snoop_ctrl_test;
    localparam int AW = 8;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_req = 1'b0, cpu_we = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic          cpu_ready;
    logic [DW-1:0] cpu_rdata;
    logic          bus_req;
    logic          bus_gnt = 1'b0;
    logic [1:0]    bus_cmd;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata, bus_rdata;
    logic          snp_valid = 1'b0, snp_own = 1'b0;
    logic [1:0]    snp_cmd = 2'd0;
    logic [AW-1:0] snp_addr = '0;
    logic          flush_valid;
    logic [DW-1:0] flush_data;

    always #10 clk = ~clk;

    msi_snoop_ctrl #(.ADDR_W(AW), .LINES(4), .DATA_W(DW)) uut (.*);

    logic [DW-1:0] mem [0:255];
    assign bus_rdata = mem[bus_addr];

    int n_chk = 0, n_fail = 0;
    int txn_n = 0;
    logic [1:0]    t_cmd  [0:4095];
    logic [AW-1:0] t_addr [0:4095];
    logic [DW-1:0] t_dat  [0:4095];
    bit gnt_en = 1'b1;

    int            m_st  [0:3];   // 0 Invalid, 1 Shared, 2 Modified
    logic [5:0]    m_tag [0:3];
    logic [DW-1:0] m_dat [0:3];

    // Bus arbiter: grants a pending request after a random wait.
    always @(negedge clk) bus_gnt <= gnt_en && bus_req && (($urandom % 4) != 0);

    // Bus monitor and memory model.
    always @(posedge clk) begin
        if (rst_n) begin
            if (bus_req && bus_gnt) begin
                if (txn_n < 4096) begin
                    t_cmd[txn_n]  <= bus_cmd;
                    t_addr[txn_n] <= bus_addr;
                    t_dat[txn_n]  <= bus_wdata;
                end
                txn_n <= txn_n + 1;
                if (bus_cmd == 2'd3) mem[bus_addr] <= bus_wdata;
            end
            if (flush_valid) mem[snp_addr] <= flush_data;
        end
    end

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic cpu_op(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] wd);
        int idx, base, cyc, n_exp;
        bit hit, dirty;
        logic [DW-1:0] exp_v, got;
        string rq;
        idx   = int'(a[1:0]);
        hit   = (m_st[idx] != 0) && (m_tag[idx] == a[7:2]);
        dirty = !hit && (m_st[idx] == 2);
        exp_v = hit ? m_dat[idx] : mem[a];
        if (!we && hit)                 begin rq = "R3"; n_exp = 0; end
        else if (we && hit && m_st[idx] == 2) begin rq = "R5"; n_exp = 0; end
        else if (dirty)                 begin rq = "R9"; n_exp = 2; end
        else if (we)                    begin rq = "R4"; n_exp = 1; end
        else                            begin rq = "R2"; n_exp = 1; end
        base = txn_n;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        cyc = 0;
        #1;
        while (!cpu_ready && cyc < 60) begin
            @(negedge clk); #1; cyc++;
        end
        got = cpu_rdata;
        chk(cpu_ready == 1'b1, rq, "request completed", longint'(cpu_ready), 1);
        @(posedge clk); @(negedge clk);
        cpu_req = 1'b0;
        #1;
        chk(txn_n - base == n_exp, rq, "bus transaction count", txn_n - base, n_exp);
        if (n_exp == 0) chk(cyc == 0, rq, "hit ready in request cycle", cyc, 0);
        if (n_exp == 2 && txn_n - base == 2) begin
            chk(t_cmd[base] == 2'd3, "R9", "write-back first", t_cmd[base], 3);
            chk(t_addr[base] == {m_tag[idx], a[1:0]}, "R9", "victim address",
                t_addr[base], {m_tag[idx], a[1:0]});
            chk(t_dat[base] == m_dat[idx], "R9", "victim word", t_dat[base], m_dat[idx]);
        end
        if (n_exp > 0 && txn_n - base == n_exp) begin
            chk(t_cmd[base+n_exp-1] == (we ? 2'd2 : 2'd1), rq, "fetch command",
                t_cmd[base+n_exp-1], we ? 2 : 1);
            chk(t_addr[base+n_exp-1] == a, rq, "fetch address", t_addr[base+n_exp-1], a);
        end
        if (!we) chk(got == exp_v, rq, "read word", got, exp_v);
        if (we) begin
            m_st[idx] = 2; m_tag[idx] = a[7:2]; m_dat[idx] = wd;
        end else if (!hit) begin
            m_st[idx] = 1; m_tag[idx] = a[7:2]; m_dat[idx] = exp_v;
        end
    endtask

    task automatic snoop(input logic [1:0] cmd, input logic [AW-1:0] a, input bit own);
        int idx;
        bit hit, exp_f;
        string rq;
        idx   = int'(a[1:0]);
        hit   = !own && (m_st[idx] != 0) && (m_tag[idx] == a[7:2]);
        exp_f = hit && (m_st[idx] == 2) && (cmd == 2'd1 || cmd == 2'd2);
        rq = own ? "R11" : (cmd == 2'd2 ? "R8" : (exp_f ? "R6" : "R7"));
        @(negedge clk);
        snp_valid = 1'b1; snp_cmd = cmd; snp_addr = a; snp_own = own;
        #1;
        chk(flush_valid == exp_f, rq, "flush_valid", flush_valid, exp_f);
        if (exp_f) chk(flush_data == m_dat[idx], rq, "flush word", flush_data, m_dat[idx]);
        @(posedge clk); @(negedge clk);
        snp_valid = 1'b0; snp_own = 1'b0; snp_cmd = 2'd0;
        if (hit && cmd == 2'd1 && m_st[idx] == 2) m_st[idx] = 1;
        if (hit && cmd == 2'd2) m_st[idx] = 0;
    endtask

    initial begin : watchdog
        #(20 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        int base, cyc;
        logic [DW-1:0] exp_v;
        void'($urandom(32'd4242));
        for (int i = 0; i < 256; i++) mem[i] = DW'(i * 16'h0131) ^ 16'h5a5a;
        for (int i = 0; i < 4; i++) begin m_st[i] = 0; m_tag[i] = '0; m_dat[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state at the ports
        chk(cpu_ready == 1'b0, "R1", "cpu_ready after reset", cpu_ready, 0);
        chk(bus_req == 1'b0, "R1", "bus_req after reset", bus_req, 0);
        chk(flush_valid == 1'b0, "R1", "flush_valid after reset", flush_valid, 0);
        snoop(2'd2, 8'h00, 1'b0);          // R1: no line valid, no flush
        cpu_op(1'b0, 8'h05, '0);           // R2 miss
        cpu_op(1'b0, 8'h05, '0);           // R3 hit in Shared
        snoop(2'd1, 8'h05, 1'b0);          // R7 snoop read on Shared
        cpu_op(1'b0, 8'h05, '0);           // R7: still a hit
        cpu_op(1'b1, 8'h05, 16'h1111);     // R4 write hit Shared
        cpu_op(1'b1, 8'h05, 16'h2222);     // R5 write hit Modified
        cpu_op(1'b0, 8'h05, '0);           // R3 read hit Modified
        snoop(2'd2, 8'h05, 1'b1);          // R11 own read-for-ownership ignored
        cpu_op(1'b1, 8'h05, 16'h3333);     // R11: still Modified, no bus
        snoop(2'd1, 8'h05, 1'b0);          // R6 flush, to Shared
        cpu_op(1'b1, 8'h05, 16'h4444);     // R6: write now needs ownership
        snoop(2'd2, 8'h05, 1'b0);          // R8 flush and invalidate
        cpu_op(1'b0, 8'h05, '0);           // R8: miss returns flushed word
        cpu_op(1'b1, 8'h09, 16'h5555);     // R4 write miss
        cpu_op(1'b0, 8'h0D, '0);           // R9 dirty victim
        cpu_op(1'b0, 8'h11, '0);           // R9 clean victim, silent

        // R10: victim taken by a snoop while the write-back waits for grant
        cpu_op(1'b1, 8'h02, 16'h6666);
        gnt_en = 1'b0;
        base = txn_n;
        exp_v = mem[8'h06];
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 8'h06;
        @(negedge clk); @(negedge clk);
        #1;
        chk(bus_req == 1'b1, "R13", "request held without grant", bus_req, 1);
        snp_valid = 1'b1; snp_cmd = 2'd2; snp_addr = 8'h02; snp_own = 1'b0;
        #1;
        chk(flush_valid == 1'b1, "R10", "victim flushed by snoop", flush_valid, 1);
        chk(flush_data == 16'h6666, "R10", "victim flush word", flush_data, 16'h6666);
        @(negedge clk);
        snp_valid = 1'b0; snp_cmd = 2'd0;
        m_st[2] = 0;
        gnt_en = 1'b1;
        cyc = 0;
        #1;
        while (!cpu_ready && cyc < 60) begin @(negedge clk); #1; cyc++; end
        chk(cpu_rdata == exp_v, "R10", "read word after lost victim", cpu_rdata, exp_v);
        @(posedge clk); @(negedge clk);
        cpu_req = 1'b0;
        #1;
        chk(txn_n - base == 1, "R10", "write-back dropped", txn_n - base, 1);
        chk(t_cmd[base] == 2'd1, "R10", "only fetch issued", t_cmd[base], 1);
        chk(mem[8'h02] == 16'h6666, "R10", "memory holds flushed word", mem[8'h02], 16'h6666);
        m_st[2] = 1; m_tag[2] = 6'h01; m_dat[2] = exp_v;

        // R12: foreign snoop collides with a new read hit on 0x11
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 8'h11;
        snp_valid = 1'b1; snp_cmd = 2'd1; snp_addr = 8'h30; snp_own = 1'b0;
        #1;
        chk(cpu_ready == 1'b0, "R12", "request stalled by snoop", cpu_ready, 0);
        @(negedge clk);
        snp_valid = 1'b0; snp_cmd = 2'd0;
        #1;
        chk(cpu_ready == 1'b1, "R12", "request served after snoop", cpu_ready, 1);
        chk(cpu_rdata == m_dat[1], "R12", "read word", cpu_rdata, m_dat[1]);
        @(posedge clk); @(negedge clk);
        cpu_req = 1'b0;

        // Random mix over conflicting addresses
        for (int k = 0; k < 400; k++) begin
            int op;
            logic [AW-1:0] a;
            op = int'($urandom % 6);
            a  = AW'($urandom % 16);
            case (op)
                0, 1: cpu_op(1'b0, a, '0);
                2, 3: cpu_op(1'b1, a, DW'($urandom));
                4:    snoop(2'd1, a, ($urandom % 4) == 0);
                default: snoop(2'd2, a, ($urandom % 4) == 0);
            endcase
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule